// File: doc/BRIEF.md
# Symmetric FIR Pre-Adder Data Path

This block is the front end of a symmetric FIR filter. Each accepted input sample enters a forward chain of taps. The spacing between neighbouring taps is programmable from 1 to 16 sample periods. For every tap pair, a small ALU combines a sample from the first half of the chain (input A) with a partner sample (input B). One coefficient downstream can then serve both taps of the pair.

The partner is normally the mirror tap, so the first tap pairs with the last. When reversal is turned off, the partner is instead the tap half a chain further along, in the same order. An odd-length mode shrinks the chain by one tap. In that mode the centre tap contributes only its forward sample. An interleave mode tags each result with an alternating phase bit, so that two interleaved channels can be told apart. Coefficient multiply, accumulation and output formatting belong to the blocks that follow.

Samples arrive on a valid/ready stream, and the per-pair sums leave on another valid/ready stream. The input is accepted only when the output register is empty, or is being emptied in the same cycle. A held output stays unchanged until the consumer takes it. Each accepted sample produces exactly one result, and results leave in order. The configuration pins are plain levels. They are registered once before use.

Top module: `sym_preadd`

## Requirements
- R1: Forward tap k holds the sample accepted k*(cfg_len+1) samples before the newest one, which is tap 0. cfg_len code 0 gives a spacing of 1, and code 15 gives a spacing of 16.
- R2: With cfg_sub=0 each pair outputs A+B. With cfg_sub=1 it outputs B−A. Results are signed two's complement, DATA_W+1 bits wide, and pair k sits at out_sum[k*(DATA_W+1) +: DATA_W+1].
- R3: With cfg_pass_a=0 input A is zero. With cfg_pass_a=1 input A of pair k is forward tap k.
- R4: With cfg_pass_b=0 input B is zero. With cfg_pass_b=1 input B comes from the partner tap.
- R5: With cfg_rev_n=0 (reversal on), the partner of pair k is tap T−1−k, where T is the tap count. With cfg_rev_n=1 (reversal off), the partner is tap N_PAIRS+k.
- R6: With cfg_odd=0, T=2*N_PAIRS. With cfg_odd=1, T=2*N_PAIRS−1, and the centre pair (index N_PAIRS−1) has B forced to zero.
- R7: With cfg_ilv=1 the out_phase tag alternates on each accepted sample, and the first sample after enabling is tagged 0. With cfg_ilv=0 the tag is 0.
- R8: in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, out_sum and out_phase hold steady. Each accepted sample yields one result, in order.
- R9: clr zeroes every delay register and the interleave phase, and drops any pending result. A sample offered in the same cycle is discarded.
- R10: A configuration pin value is applied one clock edge after it is sampled. A sample accepted on the same edge as a configuration change uses the old setting.
- R11: After reset, out_valid is 0, in_ready is 1, and all taps read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the delay chain and pending result |
| cfg_sub | input | 1 | ALU operation: 0 A+B, 1 B−A |
| cfg_pass_a | input | 1 | 1 feeds A from the forward tap, 0 forces zero |
| cfg_pass_b | input | 1 | 1 feeds B from the partner tap, 0 forces zero |
| cfg_len | input | LEN_W (4) | Tap spacing minus one |
| cfg_odd | input | 1 | 1 selects an odd tap count |
| cfg_rev_n | input | 1 | 0 mirrored pairing, 1 same-direction pairing |
| cfg_ilv | input | 1 | 1 enables the alternating phase tag |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | DATA_W (12) | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | N_PAIRS*(DATA_W+1) (52) | Per-pair signed sums |
| out_phase | output | 1 | Interleave phase tag of the result |

## Verification
The bench runs long streams at spacings of 1, 2 and 16. An off-by-one in the spacing code would pair each sample with its neighbour's partner and corrupt every sum. Odd mode is run with reversal both on and off; a design that let the centre tap add its own B would double the centre sample. Back-pressure is applied in a stop-and-go pattern, which exposes a design that drops a result, duplicates one, or lets a held result drift. The bench also flips the ALU mode on the same edge as a sample and clears the chain while a result is pending. A design that applied configuration at once, or kept stale data after a clear, would then give a wrong sum or a spurious result.

// File: rtl/sym_preadd_pkg.sv
package sym_preadd_pkg;
  // Registered mode bits of the pre-adder
  typedef struct packed {
    logic sub;
    logic pass_a;
    logic pass_b;
    logic odd;
    logic rev_n;
    logic ilv;
  } pad_mode_t;
endpackage

// File: rtl/pad_delay_line.sv
module pad_delay_line #(
  parameter int W     = 12,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                shift,
  input  logic [LW-1:0]       len_code,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] tap_now,
  output logic signed [W-1:0] tap_next
);
  logic signed [W-1:0] line [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else if (shift) begin
      line[0] <= din;
      for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
    end
  end

  // Current tap and the value it takes after the next shift
  assign tap_now  = line[len_code];
  assign tap_next = (len_code == '0) ? din : line[len_code - 1'b1];

  // R1: the first register captures the incoming sample on a shift
  assert_shift_R1: assert property (@(posedge clk) disable iff (rst)
    (shift && !clr) |=> (line[0] == $past(din)));
endmodule

// File: rtl/pad_pair_select.sv
module pad_pair_select #(
  parameter int W = 12,
  parameter int P = 4,
  localparam int T = 2 * P
) (
  input  logic                odd,
  input  logic                rev_n,
  input  logic signed [W-1:0] taps [T],
  output logic signed [W-1:0] a_src [P],
  output logic signed [W-1:0] b_src [P]
);
  for (genvar k = 0; k < P; k++) begin : g_pair
    assign a_src[k] = taps[k];
    if (k == P - 1) begin : g_centre
      // Centre pair: forward sample only in odd mode
      assign b_src[k] = odd ? '0 : (rev_n ? taps[P + k] : taps[T - 1 - k]);
    end else begin : g_outer
      assign b_src[k] = rev_n ? taps[P + k]
                              : (odd ? taps[T - 2 - k] : taps[T - 1 - k]);
    end
  end

  // R6: in odd mode the centre partner never contributes
  always_comb begin
    if (odd) assert_centre_R6: assert (b_src[P-1] == '0);
  end
endmodule

// File: rtl/pad_alu.sv
module pad_alu #(
  parameter int W  = 12,
  parameter int SW = W + 1
) (
  input  logic                 sub,
  input  logic                 pass_a,
  input  logic                 pass_b,
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  b,
  output logic signed [SW-1:0] res
);
  logic signed [SW-1:0] ae, be;

  always_comb begin
    ae  = pass_a ? {{(SW-W){a[W-1]}}, a} : '0;
    be  = pass_b ? {{(SW-W){b[W-1]}}, b} : '0;
    res = sub ? (be - ae) : (ae + be);
  end

  // R3 / R4: with both inputs gated the result is zero in either mode
  always_comb begin
    if (!pass_a && !pass_b) assert_gated_R3: assert (res == '0);
  end
endmodule

// File: rtl/sym_preadd.sv
module sym_preadd
  import sym_preadd_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int N_PAIRS = 4,
  parameter int MAX_LEN = 16,
  localparam int LEN_W  = $clog2(MAX_LEN),
  localparam int SUM_W  = DATA_W + 1,
  localparam int N_TAPS = 2 * N_PAIRS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       cfg_sub,
  input  logic                       cfg_pass_a,
  input  logic                       cfg_pass_b,
  input  logic [LEN_W-1:0]           cfg_len,
  input  logic                       cfg_odd,
  input  logic                       cfg_rev_n,
  input  logic                       cfg_ilv,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [N_PAIRS*SUM_W-1:0]   out_sum,
  output logic                       out_phase
);
  pad_mode_t        mode_q;
  logic [LEN_W-1:0] len_q;
  logic             accept;
  logic             ph_q;

  logic signed [DATA_W-1:0] taps_now  [N_TAPS];
  logic signed [DATA_W-1:0] taps_next [N_TAPS];
  logic signed [DATA_W-1:0] a_src [N_PAIRS];
  logic signed [DATA_W-1:0] b_src [N_PAIRS];
  logic signed [SUM_W-1:0]  res   [N_PAIRS];
  logic signed [SUM_W-1:0]  out_q [N_PAIRS];
  logic signed [DATA_W-1:0] tap0_q;

  // Configuration register: one edge of latency
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      len_q  <= '0;
    end else begin
      mode_q <= '{sub: cfg_sub, pass_a: cfg_pass_a, pass_b: cfg_pass_b,
                  odd: cfg_odd, rev_n: cfg_rev_n, ilv: cfg_ilv};
      len_q  <= cfg_len;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready && !clr;

  // Tap 0: the newest sample
  always_ff @(posedge clk) begin
    if (rst || clr)  tap0_q <= '0;
    else if (accept) tap0_q <= in_data;
  end
  assign taps_now[0]  = tap0_q;
  assign taps_next[0] = in_data;

  for (genvar k = 1; k < N_TAPS; k++) begin : g_line
    pad_delay_line #(.W(DATA_W), .DEPTH(MAX_LEN)) u_line (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .shift    (accept),
      .len_code (len_q),
      .din      (taps_now[k-1]),
      .tap_now  (taps_now[k]),
      .tap_next (taps_next[k])
    );
  end

  pad_pair_select #(.W(DATA_W), .P(N_PAIRS)) u_sel (
    .odd   (mode_q.odd),
    .rev_n (mode_q.rev_n),
    .taps  (taps_next),
    .a_src (a_src),
    .b_src (b_src)
  );

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_alu
    pad_alu #(.W(DATA_W), .SW(SUM_W)) u_alu (
      .sub    (mode_q.sub),
      .pass_a (mode_q.pass_a),
      .pass_b (mode_q.pass_b),
      .a      (a_src[k]),
      .b      (b_src[k]),
      .res    (res[k])
    );
    assign out_sum[k*SUM_W +: SUM_W] = out_q[k];
  end

  // Output register stage
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_valid <= 1'b0;
      out_phase <= 1'b0;
      ph_q      <= 1'b0;
      for (int k = 0; k < N_PAIRS; k++) out_q[k] <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_phase <= mode_q.ilv ? ph_q : 1'b0;
      ph_q      <= mode_q.ilv ? !ph_q : 1'b0;
      for (int k = 0; k < N_PAIRS; k++) out_q[k] <= res[k];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: an accepted sample always produces a result
  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  // R8: a stalled result holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_sum) && $stable(out_phase)));
  // R9: clear drops the pending result
  assert_clr_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !out_valid);
  // R7: without interleave the tag is zero
  assert_phase_off_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && !mode_q.ilv) |=> !out_phase);
  // R10: the ALU mode follows its pin one edge later
  assert_cfg_delay_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mode_q.sub == $past(cfg_sub)));
endmodule

// File: tb/sim_sym_preadd.sv
module sim_sym_preadd;
  localparam int CLK_P = 10;
  localparam int DW = 12;
  localparam int P = 4;
  localparam int ML = 16;
  localparam int SW = DW + 1;
  localparam int HN = (2 * P - 1) * ML + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic c_sub = 0, c_pa = 0, c_pb = 0, c_odd = 0, c_revn = 0, c_ilv = 0;
  logic [3:0] c_len = '0;
  logic e_sub = 0, e_pa = 0, e_pb = 0, e_odd = 0, e_revn = 0, e_ilv = 0;
  logic [3:0] e_len = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [P*SW-1:0] out_sum;
  logic out_phase;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  int cyc = 0;
  string cur_req = "R11";
  logic [P*SW-1:0] q_sum [$];
  logic q_ph [$];
  string q_req [$];
  logic signed [DW-1:0] hist [HN];
  logic m_ph = 1'b0;
  logic held_v = 1'b0;
  logic [P*SW-1:0] held_sum;
  logic held_ph;

  always #(CLK_P/2) clk = ~clk;

  sym_preadd u0 (
    .clk(clk), .rst(rst), .clr(clr),
    .cfg_sub(c_sub), .cfg_pass_a(c_pa), .cfg_pass_b(c_pb), .cfg_len(c_len),
    .cfg_odd(c_odd), .cfg_rev_n(c_revn), .cfg_ilv(c_ilv),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_phase(out_phase)
  );

  // Bench copy of the effective configuration (R10: one edge late)
  always @(posedge clk) begin
    e_sub <= c_sub; e_pa <= c_pa; e_pb <= c_pb; e_odd <= c_odd;
    e_revn <= c_revn; e_ilv <= c_ilv; e_len <= c_len;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [P*SW-1:0] act, input logic [P*SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [P*SW-1:0] model();
    logic [P*SW-1:0] r;
    int len, t, a, b, s, idx;
    bit centre;
    len = int'(e_len) + 1;
    t = e_odd ? 2 * P - 1 : 2 * P;
    r = '0;
    for (int k = 0; k < P; k++) begin
      a = e_pa ? int'(hist[k * len]) : 0;
      centre = e_odd && (k == P - 1);
      idx = e_revn ? P + k : t - 1 - k;
      b = (!centre && e_pb) ? int'(hist[idx * len]) : 0;
      s = e_sub ? b - a : a + b;
      r[k*SW +: SW] = SW'(s);
    end
    return r;
  endfunction

  // Driver: offer one sample; optionally flip the ALU mode on the same edge
  task automatic send(input logic [DW-1:0] d, input bit flip);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    if (flip) c_sub = ~c_sub;
    forever begin
      #2;
      if (in_ready) begin
        for (int i = HN - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = d;
        q_sum.push_back(model());
        q_ph.push_back(e_ilv ? m_ph : 1'b0);
        m_ph = e_ilv ? ~m_ph : 1'b0;
        q_req.push_back(cur_req);
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic stream(input int n);
    for (int i = 0; i < n; i++) send(DW'($urandom), 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 1000 && q_sum.size() != 0; i++) @(negedge clk);
    check(q_sum.size() == 0, "R8", "queue drained", P*SW'(q_sum.size()), '0);
  endtask

  task automatic do_clr();
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    q_sum.delete(); q_ph.delete(); q_req.delete();
    for (int i = 0; i < HN; i++) hist[i] = '0;
    m_ph = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    check(out_valid == 1'b0, "R9", "out_valid after clr", P*SW'(out_valid), '0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    #1;
    if (!rst && !clr) begin
      if (held_v && out_valid)
        check(out_sum == held_sum && out_phase == held_ph, "R8", "held result moved",
              out_sum, held_sum);
      held_v = out_valid && !out_ready;
      held_sum = out_sum;
      held_ph = out_phase;
      if (out_valid && out_ready) begin
        if (q_sum.size() == 0) begin
          check(1'b0, "R8", "unexpected result", out_sum, '0);
        end else begin
          logic [P*SW-1:0] es;
          logic ep;
          string er;
          es = q_sum.pop_front();
          ep = q_ph.pop_front();
          er = q_req.pop_front();
          check(out_sum == es, er, "pair sums", out_sum, es);
          check(out_phase == ep, er, "phase tag", P*SW'(out_phase), P*SW'(ep));
        end
      end
    end else begin
      held_v = 1'b0;
    end
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < HN; i++) hist[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", P*SW'(out_valid), '0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", P*SW'(in_ready), 1);

    // R1 R2 R5: spacing 1, add, mirrored pairing, taps start at zero (R11)
    c_pa = 1; c_pb = 1;
    @(negedge clk); @(negedge clk);
    cur_req = "R1 R2 R5 R11";
    stream(20); drain();

    // R2 R8: subtract under stop-and-go back-pressure
    c_sub = 1; rdy_mode = 1;
    @(negedge clk); @(negedge clk);
    cur_req = "R2 R8";
    stream(20); drain();

    // R3: A gated off
    c_sub = 0; c_pa = 0;
    @(negedge clk); @(negedge clk);
    cur_req = "R3";
    stream(10); drain();

    // R4: B gated off, subtract
    c_pa = 1; c_pb = 0; c_sub = 1;
    @(negedge clk); @(negedge clk);
    cur_req = "R4";
    stream(10); drain();

    // R5: same-direction pairing
    c_pb = 1; c_sub = 0; c_revn = 1;
    @(negedge clk); @(negedge clk);
    cur_req = "R5";
    stream(15); drain();

    // R6: odd tap count, both pairing directions
    c_odd = 1; c_revn = 0;
    @(negedge clk); @(negedge clk);
    cur_req = "R6";
    stream(15); drain();
    c_revn = 1; c_sub = 1;
    @(negedge clk); @(negedge clk);
    stream(15); drain();

    // R1 R9: clear, then longest spacing
    c_odd = 0; c_revn = 0; c_sub = 0; rdy_mode = 0;
    do_clr();
    c_len = 4'd15;
    @(negedge clk); @(negedge clk);
    cur_req = "R1 R9";
    stream(130); drain();

    // R7: interleave tag with spacing 2
    do_clr();
    c_len = 4'd1; c_ilv = 1; rdy_mode = 1;
    @(negedge clk); @(negedge clk);
    cur_req = "R7";
    stream(25); drain();
    c_ilv = 0;
    @(negedge clk); @(negedge clk);
    stream(6); drain();

    // R10: mode flips on the same edge as a sample
    do_clr();
    c_len = 4'd0; rdy_mode = 0;
    @(negedge clk); @(negedge clk);
    cur_req = "R10";
    send(12'h123, 1'b0);
    send(12'h7ff, 1'b1);
    send(12'h800, 1'b0);
    send(12'h0f0, 1'b1);
    send(12'h055, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R9: clear while a result is held
    rdy_mode = 2;
    out_ready = 1'b0;
    cur_req = "R9";
    send(12'h3a5, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    do_clr();
    rdy_mode = 0;
    @(negedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R9", "no result after clr", P*SW'(out_valid), '0);
    send(12'h001, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    drain();

    finish_run();
  end
endmodule